// File: doc/BRIEF.md
# Wired-AND SCL Clock Generator

This block produces the serial clock of an I2C master on a line that is shared, wired-AND fashion, with other masters and with slaves. It never drives the line high. It only asks for the line to be pulled low, through an open-drain request, and it releases that request to let the pull-up raise the line. It times its low and high phases from the filtered level of the shared line. A falling edge made by any device starts a new low phase. A high phase is counted only once the line is really seen high. As a result, competing masters fall into step with each other, and a slave can stretch the clock by holding the line low.

Two 16-bit counts set the phase lengths, in system clock cycles: one for the low phase and one for the high phase. The block reads the matching count when a phase begins. A count of zero acts as a count of one. After its own low phase runs out, the block may find the line still held low by another device. In that case it lets go and raises a wait flag until the line rises.

Top module: `scl_sync_gen`

## Requirements
- R1: When `enable` is low, the block releases the line (`scl_pull` = 0) and `high_wait` is 0 from the next cycle on. This includes a disable in the middle of a low phase. Reset gives the same state.
- R2: Once the block starts pulling, it keeps `scl_pull` high for exactly max(L,1) consecutive cycles, where L is the low count.
- R3: The release lasts max(H,1)+1 cycles when no other device interferes: one cycle in which the risen line is observed, then max(H,1) counted cycles. H is the high count. After that the block pulls again.
- R4: Another device may pull the line low while the block is counting its high phase. The block then drops its high count and asserts `scl_pull` in the next cycle, for a fresh full low phase of max(L,1) cycles.
- R5: If the line is still low when the block's low count runs out, the block releases and waits without counting. The bus low time becomes max(max(L,1), S), where S is the cycles that a slave holds the line from the start of the low phase. The high count starts only after the line rises.
- R6: A low or high count of 0 behaves exactly like a count of 1.
- R7: Each count is read when its phase begins. Changing `low_count` during a low phase changes the next low phase, not the current one.
- R8: `high_wait` is 1 exactly in the cycles where the block is enabled and active, is not pulling, and the filtered line is low. This covers the wait after a low phase and the case of being enabled while another device holds the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the generator when high; forces idle when low |
| scl_in | input | 1 | Filtered, synchronized level of the shared clock line |
| low_count | input | 16 | Low phase length in system clock cycles (0 acts as 1) |
| high_count | input | 16 | High phase length in system clock cycles (0 acts as 1) |
| scl_pull | output | 1 | Open-drain request: 1 pulls the line low, 0 releases it |
| high_wait | output | 1 | Released but the line is still held low |

## Verification
Every cycle, the assertions check these properties:
- Disabling releases the line.
- A running low count keeps the pull active.
- A falling line during the high count starts a low phase on the next cycle.
- The wait state never pulls.
- A risen line moves the block into its high count.
- An active count is never zero.
- The wait flag appears only while the line is low and the block is released.

Only the bench scenarios can show exact phase lengths, because these need cycle counting over whole periods. The scenarios cover the stretched low time with a slave model, and the point at which a changed count takes effect. They also cover the reaction to a second master that pulls the line in the middle of the high phase.

// File: rtl/scl_gen_pkg.sv
// Package: shared types for the wired-AND SCL clock generator.
// Assumes nothing beyond standard SystemVerilog enum support.
package scl_gen_pkg;

    // Phase of the clock generator.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // disabled, line released
        PH_HIGH = 2'd1,  // line seen high, counting high phase
        PH_LOW  = 2'd2,  // pulling the line, counting low phase
        PH_WAIT = 2'd3   // released, waiting for the line to rise
    } phase_t;

    // Which programmed count is loaded at a phase start.
    typedef enum logic {
        SEL_HIGH = 1'b0,
        SEL_LOW  = 1'b1
    } cnt_sel_t;

endpackage

// File: rtl/scl_period_counter.sv
// Module: down counter that times one clock phase.
// Loads a programmed count (0 is promoted to 1) at a phase start and
// counts down to 1. It assumes the controller issues load, dec and clr
// one at a time, with clr winning.
module scl_period_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] load_eff;

    // Promote a zero count to one cycle.
    always_comb load_eff = (load_val == '0) ? ONE : load_val;

    // Hold, load or decrement the phase count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_eff;
        end else if (dec && (cnt > ONE)) begin
            cnt <= cnt - ONE;
        end
    end

    // Flag the final cycle of a phase.
    always_comb last = (cnt <= ONE);

endmodule

// File: rtl/scl_phase_fsm.sv
// Module: phase controller for the SCL generator.
// Moves between idle, high count, low count and high wait, based on the
// filtered line level and the counter's last-cycle flag. It assumes that
// scl_in is already synchronized and deglitched.
module scl_phase_fsm
    import scl_gen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     scl_in,
    input  logic     cnt_last,
    output phase_t   phase,
    output logic     cnt_load,
    output cnt_sel_t cnt_sel,
    output logic     cnt_dec,
    output logic     cnt_clr
);

    phase_t phase_nxt;

    // Compute the next phase and the counter commands.
    always_comb begin
        phase_nxt = phase;
        cnt_load  = 1'b0;
        cnt_sel   = SEL_HIGH;
        cnt_dec   = 1'b0;
        cnt_clr   = 1'b0;
        if (!enable) begin
            phase_nxt = PH_IDLE;
            cnt_clr   = 1'b1;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (scl_in) begin
                        phase_nxt = PH_HIGH;
                        cnt_load  = 1'b1;
                        cnt_sel   = SEL_HIGH;
                    end else begin
                        phase_nxt = PH_WAIT;
                    end
                end
                PH_HIGH: begin
                    if (!scl_in || cnt_last) begin
                        phase_nxt = PH_LOW;
                        cnt_load  = 1'b1;
                        cnt_sel   = SEL_LOW;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt_last) begin
                        phase_nxt = PH_WAIT;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (scl_in) begin
                        phase_nxt = PH_HIGH;
                        cnt_load  = 1'b1;
                        cnt_sel   = SEL_HIGH;
                    end
                end
                default: phase_nxt = PH_IDLE;
            endcase
        end
    end

    // Register the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nxt;
        end
    end

endmodule

// File: rtl/scl_sync_gen.sv
// Module: wired-AND SCL clock generator (top).
// Produces an open-drain pull request for a shared clock line. Low and
// high phases are timed from the observed line level, so the block
// stays in step with other masters and honours clock stretching. It
// assumes that scl_in is the filtered line level and reflects the
// block's own pull within the same cycle or later.
module scl_sync_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] low_count,
    input  logic [CNT_W-1:0] high_count,
    output logic             scl_pull,
    output logic             high_wait
);

    phase_t           phase;
    cnt_sel_t         cnt_sel;
    logic             cnt_load;
    logic             cnt_dec;
    logic             cnt_clr;
    logic             cnt_last;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;

    scl_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .scl_in   (scl_in),
        .cnt_last (cnt_last),
        .phase    (phase),
        .cnt_load (cnt_load),
        .cnt_sel  (cnt_sel),
        .cnt_dec  (cnt_dec),
        .cnt_clr  (cnt_clr)
    );

    // Choose the programmed count for the phase about to start.
    always_comb load_val = (cnt_sel == SEL_LOW) ? low_count : high_count;

    scl_period_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .load     (cnt_load),
        .load_val (load_val),
        .dec      (cnt_dec),
        .cnt      (cnt),
        .last     (cnt_last)
    );

    // Pull the line only during the low phase.
    always_comb scl_pull = (phase == PH_LOW);

    // Flag an active, released block that sees the line low.
    always_comb high_wait = ((phase == PH_HIGH) || (phase == PH_WAIT)) && !scl_in;

endmodule

// File: rtl/scl_sync_gen_chk.sv
// Module: assertion checker bound to scl_sync_gen.
// Watches the ports and the phase/counter state every cycle.
module scl_sync_gen_chk
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             scl_in,
    input logic             scl_pull,
    input logic             high_wait,
    input phase_t           phase,
    input logic             cnt_last,
    input logic [CNT_W-1:0] cnt
);

    AST_DISABLED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_pull && !high_wait)); // R1

    AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_LOW && !cnt_last) |=> scl_pull); // R2

    AST_RISE_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_WAIT && scl_in) |=> (phase == PH_HIGH)); // R3

    AST_FALL_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_HIGH && !scl_in) |=> scl_pull); // R4

    AST_WAIT_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_WAIT) |=> !scl_pull); // R5

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH || phase == PH_LOW) |-> (cnt != '0)); // R6

    AST_WAIT_FLAG_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        high_wait |-> (!scl_pull && !scl_in)); // R8

endmodule

bind scl_sync_gen scl_sync_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .scl_in    (scl_in),
    .scl_pull  (scl_pull),
    .high_wait (high_wait),
    .phase     (phase),
    .cnt_last  (cnt_last),
    .cnt       (cnt)
);

// File: tb/scl_sync_gen_tb.sv
`timescale 1ns/1ps
// Bench: models the shared line as the wired-AND of the DUT pull, a
// stretching slave and a second master, and measures phase lengths.
module scl_sync_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] low_count = 16'd0;
    logic [15:0] high_count = 16'd0;
    logic        scl_pull;
    logic        high_wait;
    logic        slave_hold = 1'b0;
    logic        other_hold = 1'b0;
    logic        bus;
    int          n_chk = 0;
    int          n_fail = 0;

    // Wired-AND line: low if any device pulls.
    assign bus = !(scl_pull || slave_hold || other_hold);

    always #2.5 clk = ~clk;

    scl_sync_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .scl_in     (bus),
        .low_count  (low_count),
        .high_count (high_count),
        .scl_pull   (scl_pull),
        .high_wait  (high_wait)
    );

    // Vectors: low count, high count, slave hold cycles.
    localparam int NV = 6;
    localparam int VEC [NV][3] = '{
        '{4, 3, 0}, '{0, 0, 0}, '{5, 2, 9},
        '{6, 4, 3}, '{3, 1, 3}, '{1, 0, 4}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance to the next sampling point (1 ns after a falling edge).
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_pull();
        for (int i = 0; i < 500 && !scl_pull; i++) step();
    endtask

    // At a sample point with scl_pull high, count the cycles of the run.
    task automatic pull_run(output int n);
        n = 0;
        for (int i = 0; i < 500 && scl_pull; i++) begin
            n++;
            step();
        end
    endtask

    task automatic restart(input int l, input int h);
        @(negedge clk);
        enable = 1'b0;
        step();
        low_count  = 16'(l);
        high_count = 16'(h);
        enable     = 1'b1;
    endtask

    initial begin
        int pc, hwc, lc, hc, lp, hp, s, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1 reset pull", int'(scl_pull), 0);
        chk("R1 reset wait flag", int'(high_wait), 0);

        // Table-driven period measurements.
        for (int v = 0; v < NV; v++) begin
            restart(VEC[v][0], VEC[v][1]);
            s  = VEC[v][2];
            lp = (VEC[v][0] == 0) ? 1 : VEC[v][0];
            hp = (VEC[v][1] == 0) ? 1 : VEC[v][1];
            wait_pull();
            // cycle 0 of the low phase: the slave grabs the line too
            slave_hold = (s > 0);
            #0.1;
            pc = 0; hwc = 0; lc = 0; hc = 0;
            for (int k = 0; k < 500 && !bus; k++) begin
                pc  += int'(scl_pull);
                hwc += int'(high_wait);
                lc++;
                @(negedge clk);
                slave_hold = (k + 1 < s);
                #1;
            end
            for (int k = 0; k < 500 && bus && !scl_pull; k++) begin
                hc++;
                step();
            end
            chk((VEC[v][0] == 0) ? "R6 zero low count" : "R2 pull length", pc, lp);
            chk("R5 wait cycles", hwc, (s > lp) ? s - lp : 0);
            chk("R5 bus low time", lc, (s > lp) ? s : lp);
            chk((VEC[v][1] == 0) ? "R6 zero high count" : "R3 release length", hc, hp + 1);
        end

        // R1: disable in the middle of a low phase.
        restart(20, 2);
        wait_pull();
        repeat (3) step();
        @(negedge clk);
        enable = 1'b0;
        step();
        chk("R1 disable releases", int'(scl_pull), 0);
        chk("R1 disable wait flag", int'(high_wait), 0);

        // R4: a second master pulls the line during the high count.
        restart(3, 40);
        wait_pull();
        pull_run(n);
        repeat (3) step();
        @(negedge clk);
        other_hold = 1'b1;
        #1;
        chk("R8 wait flag on foreign fall", int'(high_wait), 1);
        @(negedge clk);
        other_hold = 1'b0;
        #1;
        chk("R4 pull after foreign fall", int'(scl_pull), 1);
        pull_run(n);
        chk("R4 fresh low length", n, 3);

        // R7: counts are read at the start of a phase.
        restart(4, 3);
        wait_pull();
        low_count = 16'd10;
        pull_run(n);
        chk("R7 current low unchanged", n, 4);
        wait_pull();
        pull_run(n);
        chk("R7 next low uses new count", n, 10);

        // R8: enabled while another device holds the line low.
        @(negedge clk);
        enable = 1'b0;
        other_hold = 1'b1;
        step();
        enable = 1'b1;
        step();
        step();
        chk("R8 wait flag while held", int'(high_wait), 1);
        chk("R8 no pull while held", int'(scl_pull), 0);
        @(negedge clk);
        other_hold = 1'b0;
        #1;
        chk("R8 flag clears on rise", int'(high_wait), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule